// File: doc/BRIEF.md
# Delayed Weighted Synapse Accumulator

This block works out the weighted synaptic drive for one layer of destination neurons from the firing activity of a source layer. By default there are 64 sources and 64 destinations. Pulses from the source layer arrive on `fire_in` and are latched by source position. A `start` strobe closes the collection window and begins a computation period. During the period a sequencer visits every source/destination connection in turn, one per cycle. For a source whose latched bit is set, it fetches that connection's signed weight and its delay, and adds the weight into a destination-delay table. The delay picks the time slot that receives the weight.

The table holds one column per delay slot. At the end of each period the front column is emitted as the current totals. It is then cleared and becomes the new back column, so a weight stored with delay d reaches the output d periods after the period that added it. Each emitted total also comes with an excitatory or inhibitory flag taken from its sign. The weight store has a write port, so the connection pattern can be changed while the block runs.

Top module: `syn_delay_accum`

## Requirements
- R1: After synchronous reset, `busy`, `done`, `front_exc`, `front_inh` and every `front_total` field are zero, and all table slots hold zero.
- R2: `fire_in` bits are ORed into a collection register. When `start` is accepted, the period uses that register ORed with `fire_in` of the same cycle, and the register is then cleared. Pulses that arrive after the accepting edge count toward the next period.
- R3: A source whose bit is clear in the period's latched set adds nothing, whatever its weights are.
- R4: For a latched source s and each destination d, the weight stored at address s*N_DST+d is added into the slot chosen by that connection's delay k. It is emitted at the end of the period that is k periods after the current one (k=0 means the end of the current period).
- R5: `start` is accepted only while idle. The edge that samples it is edge 1. `busy` is high from then until edge 4098 (N_SRC*N_DST accumulate cycles plus one shift cycle), and `done` is high for exactly the one cycle after edge 4098.
- R6: `start` while `busy` is high is ignored and does not change the period's timing.
- R7: `front_total`, `front_exc` and `front_inh` change only when `done` is raised. An emitted slot is cleared, so a value is never emitted twice.
- R8: `front_exc[d]` is 1 exactly when destination d's emitted total is above zero. `front_inh[d]` is 1 exactly when it is below zero. Both are 0 for a zero total.
- R9: Each addition saturates at the signed limits of ACC_BITS (+2^(ACC_BITS-1)-1 and -2^(ACC_BITS-1)). Additions are applied in ascending source order.
- R10: A write with `wr_en` high stores `wr_weight` (W_BITS two's complement) and `wr_delay` for the connection (`wr_src`, `wr_dst`). Every period that starts after the write uses the new values.
- R11: The total for destination d sits in `front_total[d*ACC_BITS +: ACC_BITS]` as two's complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fire_in | input | N_SRC | Source firing pulses, one bit per source |
| start | input | 1 | Begins a computation period when idle |
| wr_en | input | 1 | Connection write strobe |
| wr_src | input | log2(N_SRC) | Source index of the written connection |
| wr_dst | input | log2(N_DST) | Destination index of the written connection |
| wr_weight | input | W_BITS | Signed weight to store |
| wr_delay | input | DLY_BITS | Delay slot to store |
| busy | output | 1 | Period in progress |
| done | output | 1 | One-cycle pulse when fresh totals are presented |
| front_total | output | N_DST*ACC_BITS | Emitted totals, one field per destination |
| front_exc | output | N_DST | Positive-total flags |
| front_inh | output | N_DST | Negative-total flags |

## Verification
The checker properties assume that `start` is only ever sampled while the reset is low. They also assume the block is idle between a `done` pulse and the next accepted `start`. The reference comparison further assumes that connection writes happen only while `busy` is low and that every connection has been written before the first period, because the weight store is not reset. The stimulus keeps to these rules. It fills the whole store during idle time and rewrites rows only between periods. It still fires extra `fire_in` pulses and a stray `start` in the middle of a period, to exercise collection and the ignore rule.

// File: rtl/syn_pkg.sv
package syn_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_ACC,
    SEQ_SHIFT
  } seq_state_t;
endpackage

// File: rtl/syn_seq.sv
// Period sequencer: walks every connection once, then one shift cycle.
module syn_seq #(
  parameter int N_SRC = 64,
  parameter int N_DST = 64
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 start,
  output logic                                 launch,
  output logic [$clog2(N_SRC*N_DST)-1:0]       rd_addr,
  output logic                                 acc_en,
  output logic [$clog2(N_SRC*N_DST)-1:0]       acc_idx,
  output logic                                 shift_en,
  output logic                                 busy,
  output logic                                 done
);
  import syn_pkg::*;

  localparam int TOTAL = N_SRC * N_DST;
  localparam int IDX_W = $clog2(TOTAL);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(TOTAL - 1);

  seq_state_t       state;
  logic [IDX_W-1:0] cnt;

  assign launch   = (state == SEQ_IDLE) && start;
  // Read one entry ahead so the memory output lines up with cnt.
  assign rd_addr  = launch ? '0 : cnt + 1'b1;
  assign acc_en   = (state == SEQ_ACC);
  assign acc_idx  = cnt;
  assign shift_en = (state == SEQ_SHIFT);
  assign busy     = (state != SEQ_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SEQ_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= (state == SEQ_SHIFT);
      unique case (state)
        SEQ_IDLE: begin
          if (start) begin
            state <= SEQ_ACC;
            cnt   <= '0;
          end
        end
        SEQ_ACC: begin
          if (cnt == LAST) state <= SEQ_SHIFT;
          else             cnt   <= cnt + 1'b1;
        end
        SEQ_SHIFT: state <= SEQ_IDLE;
        default:   state <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/syn_weight_ram.sv
// Simple dual-port store for {delay, weight}, synchronous read.
module syn_weight_ram #(
  parameter int DEPTH = 4096,
  parameter int WIDTH = 10
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [WIDTH-1:0]         wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [WIDTH-1:0]         rdata
);
  logic [WIDTH-1:0] mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/syn_fire_capture.sv
// Double-buffered firing register: collect while running, freeze on launch.
module syn_fire_capture #(
  parameter int N_SRC = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] fire_in,
  input  logic             launch,
  output logic [N_SRC-1:0] work
);
  logic [N_SRC-1:0] collect;

  always_ff @(posedge clk) begin
    if (rst) begin
      collect <= '0;
      work    <= '0;
    end else if (launch) begin
      work    <= collect | fire_in;
      collect <= '0;
    end else begin
      collect <= collect | fire_in;
    end
  end
endmodule

// File: rtl/syn_delay_table.sv
// Destination-delay table with a rotating front pointer and saturating adds.
module syn_delay_table #(
  parameter int N_DST    = 64,
  parameter int ACC_BITS = 16,
  parameter int W_BITS   = 8,
  parameter int DLY_BITS = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       acc_en,
  input  logic [$clog2(N_DST)-1:0]   acc_dst,
  input  logic [W_BITS-1:0]          acc_w,
  input  logic [DLY_BITS-1:0]        acc_dly,
  input  logic                       shift_en,
  output logic [N_DST*ACC_BITS-1:0]  front_total,
  output logic [N_DST-1:0]           front_exc,
  output logic [N_DST-1:0]           front_inh
);
  localparam int NCOL = 1 << DLY_BITS;
  localparam logic signed [ACC_BITS-1:0] MAXV = {1'b0, {(ACC_BITS-1){1'b1}}};
  localparam logic signed [ACC_BITS-1:0] MINV = {1'b1, {(ACC_BITS-1){1'b0}}};

  logic signed [ACC_BITS-1:0] tbl     [NCOL][N_DST];
  logic signed [ACC_BITS-1:0] front_q [N_DST];
  logic [DLY_BITS-1:0]        head;

  logic [DLY_BITS-1:0]        col;
  logic signed [ACC_BITS:0]   cur_ext, w_ext, wide;
  logic signed [ACC_BITS-1:0] sat_val;

  assign col     = head + acc_dly;
  assign cur_ext = {tbl[col][acc_dst][ACC_BITS-1], tbl[col][acc_dst]};
  assign w_ext   = {{(ACC_BITS+1-W_BITS){acc_w[W_BITS-1]}}, acc_w};
  assign wide    = cur_ext + w_ext;

  always_comb begin
    if (wide[ACC_BITS] != wide[ACC_BITS-1])
      sat_val = wide[ACC_BITS] ? MINV : MAXV;
    else
      sat_val = wide[ACC_BITS-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head      <= '0;
      front_exc <= '0;
      front_inh <= '0;
      for (int c = 0; c < NCOL; c++)
        for (int d = 0; d < N_DST; d++)
          tbl[c][d] <= '0;
      for (int d = 0; d < N_DST; d++)
        front_q[d] <= '0;
    end else if (shift_en) begin
      for (int d = 0; d < N_DST; d++) begin
        front_q[d]      <= tbl[head][d];
        front_exc[d]    <= !tbl[head][d][ACC_BITS-1] && (tbl[head][d] != '0);
        front_inh[d]    <= tbl[head][d][ACC_BITS-1];
        tbl[head][d]    <= '0;
      end
      head <= head + 1'b1;
    end else if (acc_en) begin
      tbl[col][acc_dst] <= sat_val;
    end
  end

  for (genvar g = 0; g < N_DST; g++) begin : g_front
    assign front_total[g*ACC_BITS +: ACC_BITS] = front_q[g];
  end
endmodule

// File: rtl/syn_delay_accum.sv
// Top: serial weighted synapse accumulation into delayed time slots.
module syn_delay_accum #(
  parameter int N_SRC    = 64,
  parameter int N_DST    = 64,
  parameter int W_BITS   = 8,
  parameter int DLY_BITS = 2,
  parameter int ACC_BITS = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [N_SRC-1:0]           fire_in,
  input  logic                       start,
  input  logic                       wr_en,
  input  logic [$clog2(N_SRC)-1:0]   wr_src,
  input  logic [$clog2(N_DST)-1:0]   wr_dst,
  input  logic [W_BITS-1:0]          wr_weight,
  input  logic [DLY_BITS-1:0]        wr_delay,
  output logic                       busy,
  output logic                       done,
  output logic [N_DST*ACC_BITS-1:0]  front_total,
  output logic [N_DST-1:0]           front_exc,
  output logic [N_DST-1:0]           front_inh
);
  localparam int SRC_W  = $clog2(N_SRC);
  localparam int DST_W  = $clog2(N_DST);
  localparam int IDX_W  = SRC_W + DST_W;
  localparam int DEPTH  = N_SRC * N_DST;
  localparam int WORD_W = W_BITS + DLY_BITS;

  logic              launch, acc_en, shift_en;
  logic [IDX_W-1:0]  rd_addr, acc_idx;
  logic [WORD_W-1:0] rd_word;
  logic [N_SRC-1:0]  work;
  logic [SRC_W-1:0]  acc_src;
  logic [DST_W-1:0]  acc_dst;
  logic              acc_live;

  syn_seq #(.N_SRC(N_SRC), .N_DST(N_DST)) seq_i (
    .clk(clk), .rst(rst), .start(start), .launch(launch),
    .rd_addr(rd_addr), .acc_en(acc_en), .acc_idx(acc_idx),
    .shift_en(shift_en), .busy(busy), .done(done)
  );

  syn_weight_ram #(.DEPTH(DEPTH), .WIDTH(WORD_W)) ram_i (
    .clk(clk), .we(wr_en), .waddr({wr_src, wr_dst}),
    .wdata({wr_delay, wr_weight}), .raddr(rd_addr), .rdata(rd_word)
  );

  syn_fire_capture #(.N_SRC(N_SRC)) cap_i (
    .clk(clk), .rst(rst), .fire_in(fire_in), .launch(launch), .work(work)
  );

  assign acc_src  = acc_idx[IDX_W-1:DST_W];
  assign acc_dst  = acc_idx[DST_W-1:0];
  assign acc_live = acc_en && work[acc_src];

  syn_delay_table #(
    .N_DST(N_DST), .ACC_BITS(ACC_BITS), .W_BITS(W_BITS), .DLY_BITS(DLY_BITS)
  ) tbl_i (
    .clk(clk), .rst(rst), .acc_en(acc_live), .acc_dst(acc_dst),
    .acc_w(rd_word[W_BITS-1:0]), .acc_dly(rd_word[W_BITS +: DLY_BITS]),
    .shift_en(shift_en), .front_total(front_total),
    .front_exc(front_exc), .front_inh(front_inh)
  );
endmodule

// File: rtl/syn_delay_accum_chk.sv
// Port-level properties for syn_delay_accum, attached by bind.
module syn_delay_accum_chk #(
  parameter int N_SRC    = 64,
  parameter int N_DST    = 64,
  parameter int ACC_BITS = 16
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      busy,
  input logic                      done,
  input logic [N_DST*ACC_BITS-1:0] front_total,
  input logic [N_DST-1:0]          front_exc,
  input logic [N_DST-1:0]          front_inh
);
  localparam int MAX_BUSY = N_SRC * N_DST + 1;

  int busy_run;
  always_ff @(posedge clk) begin
    if (rst)       busy_run <= 0;
    else if (busy) busy_run <= busy_run + 1;
    else           busy_run <= 0;
  end

  // R5: done lasts one cycle
  a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R5: a period ends exactly when done rises
  a_r5_busy_end: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
  // R5: done is seen only when idle
  a_r5_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R5 R6: a period never runs longer than accumulate plus shift
  a_r5_busy_len: assert property (@(posedge clk) disable iff (rst)
    busy_run <= MAX_BUSY);
  // R7: presented totals move only with done
  a_r7_front_hold: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(front_total));
  // R8: a destination is never both excitatory and inhibitory
  a_r8_sign_excl: assert property (@(posedge clk) disable iff (rst)
    (front_exc & front_inh) == '0);
endmodule

bind syn_delay_accum syn_delay_accum_chk #(
  .N_SRC(N_SRC), .N_DST(N_DST), .ACC_BITS(ACC_BITS)
) chk_i (
  .clk(clk), .rst(rst), .busy(busy), .done(done),
  .front_total(front_total), .front_exc(front_exc), .front_inh(front_inh)
);

// File: tb/syn_delay_accum_tb_top.sv
module syn_delay_accum_tb_top;
  localparam int NS   = 64;
  localparam int ND   = 64;
  localparam int ACC  = 12;
  localparam int MAXV = (1 << (ACC - 1)) - 1;
  localparam int MINV = -(1 << (ACC - 1));
  localparam int PERIOD_EDGES = NS * ND + 2;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NS-1:0]   fire_in = '0;
  logic            start = 1'b0;
  logic            wr_en = 1'b0;
  logic [5:0]      wr_src = '0;
  logic [5:0]      wr_dst = '0;
  logic [7:0]      wr_weight = '0;
  logic [1:0]      wr_delay = '0;
  logic            busy, done;
  logic [ND*ACC-1:0] front_total;
  logic [ND-1:0]   front_exc, front_inh;

  always #4 clk = ~clk;

  syn_delay_accum #(.N_SRC(NS), .N_DST(ND), .W_BITS(8), .DLY_BITS(2), .ACC_BITS(ACC)) dut_i (
    .clk(clk), .rst(rst), .fire_in(fire_in), .start(start), .wr_en(wr_en),
    .wr_src(wr_src), .wr_dst(wr_dst), .wr_weight(wr_weight), .wr_delay(wr_delay),
    .busy(busy), .done(done), .front_total(front_total),
    .front_exc(front_exc), .front_inh(front_inh)
  );

  int checks = 0;
  int errors = 0;

  // ---------------- behavioural reference model ----------------
  int wt [NS][ND];
  int dl [NS][ND];
  int slot [4][ND];
  int front_m [ND];
  bit [NS-1:0] cap_m, work_m;
  bit busy_m, done_m;
  int cnt_m;

  function automatic int clampv(int v);
    if (v > MAXV) return MAXV;
    if (v < MINV) return MINV;
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      cap_m = '0; work_m = '0; busy_m = 0; done_m = 0; cnt_m = 0;
      for (int c = 0; c < 4; c++) for (int d = 0; d < ND; d++) slot[c][d] = 0;
      for (int d = 0; d < ND; d++) front_m[d] = 0;
    end else begin
      done_m = 0;
      if (wr_en) begin
        wt[wr_src][wr_dst] = $signed(wr_weight);
        dl[wr_src][wr_dst] = int'(wr_delay);
      end
      if (busy_m) begin
        cap_m = cap_m | fire_in;
        cnt_m++;
        if (cnt_m == PERIOD_EDGES - 1) begin
          for (int s = 0; s < NS; s++)
            if (work_m[s])
              for (int d = 0; d < ND; d++)
                slot[dl[s][d]][d] = clampv(slot[dl[s][d]][d] + wt[s][d]);
          for (int d = 0; d < ND; d++) begin
            front_m[d] = slot[0][d];
            for (int c = 0; c < 3; c++) slot[c][d] = slot[c+1][d];
            slot[3][d] = 0;
          end
          busy_m = 0;
          done_m = 1;
        end
      end else if (start) begin
        work_m = cap_m | fire_in;
        cap_m  = '0;
        busy_m = 1;
        cnt_m  = 0;
      end else begin
        cap_m = cap_m | fire_in;
      end
    end
  end

  function automatic int dut_front(int d);
    logic [ACC-1:0] f;
    f = front_total[d*ACC +: ACC];
    return int'($signed(f));
  endfunction

  // Per-clock comparison, away from the active edge.
  always @(negedge clk) begin
    if (!rst) begin
      int bad_d;
      checks += 3;
      if (done !== done_m || busy !== busy_m) begin
        errors++;
        $display("FAIL R5 done/busy actual %0b/%0b expected %0b/%0b", done, busy, done_m, busy_m);
      end
      bad_d = -1;
      for (int d = 0; d < ND; d++) if (dut_front(d) != front_m[d] && bad_d < 0) bad_d = d;
      if (bad_d >= 0) begin
        errors++;
        $display("FAIL R4 R2 front_total[%0d] actual %0d expected %0d", bad_d, dut_front(bad_d), front_m[bad_d]);
      end
      bad_d = -1;
      for (int d = 0; d < ND; d++)
        if (front_exc[d] !== (front_m[d] > 0) || front_inh[d] !== (front_m[d] < 0)) if (bad_d < 0) bad_d = d;
      if (bad_d >= 0) begin
        errors++;
        $display("FAIL R8 sign[%0d] actual exc %0b inh %0b expected total %0d", bad_d, front_exc[bad_d], front_inh[bad_d], front_m[bad_d]);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic check_eq(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic write_one(int s, int d, int w, int k);
    @(negedge clk);
    wr_en = 1'b1; wr_src = 6'(s); wr_dst = 6'(d); wr_weight = 8'(w); wr_delay = 2'(k);
  endtask

  task automatic write_rows(int lo, int hi, int w, int k);
    for (int s = lo; s <= hi; s++)
      for (int d = 0; d < ND; d++) write_one(s, d, w, k);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic run_period(logic [NS-1:0] fs, logic [NS-1:0] mid);
    int n = 0;
    @(negedge clk);
    fire_in = fs; start = 1'b1;
    forever begin
      @(posedge clk); n++;
      @(negedge clk);
      if (n == 1)   begin start = 1'b0; fire_in = '0; end
      if (n == 100) fire_in = mid;
      if (n == 101) fire_in = '0;
      if (n == 200) start = 1'b1;
      if (n == 201) start = 1'b0;
      if (done || n > PERIOD_EDGES + 50) break;
    end
    check_eq("R5 R6 edges from start to done", n, PERIOD_EDGES);
  endtask

  task automatic check_all_front(string tag, int exp);
    int bad = 0;
    for (int d = 0; d < ND; d++) if (dut_front(d) != exp) bad++;
    check_eq(tag, bad, 0);
  endtask

  bit main_done = 0;

  task automatic main_seq();
    logic [NS-1:0] fs;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check_eq("R1 busy", int'(busy), 0);
    check_eq("R1 done", int'(done), 0);
    check_eq("R1 front_total nonzero bits", $countones(front_total), 0);
    check_eq("R1 exc/inh bits", $countones(front_exc) + $countones(front_inh), 0);

    // R10 fill the whole store
    for (int s = 0; s < NS; s++)
      for (int d = 0; d < ND; d++)
        write_one(s, d, ((s * 7 + d * 3) % 41) - 20, (s + d) % 4);
    @(negedge clk); wr_en = 1'b0;

    // R2 R4 R6: three sources, mid-period pulse on source 7
    fs = '0; fs[0] = 1'b1; fs[5] = 1'b1; fs[63] = 1'b1;
    begin
      logic [NS-1:0] mid = '0;
      mid[7] = 1'b1;
      run_period(fs, mid);
    end
    check_eq("R11 field for dst 17", dut_front(17), front_m[17]);
    check_eq("R6 idle after done", int'(busy), 0);
    // drain: five empty periods
    for (int i = 0; i < 5; i++) run_period('0, '0);
    check_all_front("R7 emitted slots cleared, no re-emission", 0);

    // R3: only a zero-weight source fires, all other rows left unfired
    write_rows(2, 2, 0, 0);
    fs = '0; fs[2] = 1'b1;
    run_period(fs, '0);
    check_all_front("R3 unfired sources add nothing", 0);

    // R9 R10 positive saturation through delay 3
    write_rows(10, 30, 127, 3);
    fs = '0; for (int s = 10; s <= 30; s++) fs[s] = 1'b1;
    run_period(fs, '0);
    check_all_front("R4 delay 3 slot not yet emitted", 0);
    for (int i = 0; i < 3; i++) run_period('0, '0);
    check_all_front("R9 R10 positive saturation", MAXV);
    check_eq("R8 all excitatory", $countones(front_exc), ND);

    // R9 negative saturation through delay 0
    write_rows(40, 59, -128, 0);
    fs = '0; for (int s = 40; s <= 59; s++) fs[s] = 1'b1;
    run_period(fs, '0);
    check_all_front("R9 negative saturation", MINV);
    check_eq("R8 all inhibitory", $countones(front_inh), ND);

    // every source fires
    run_period('1, '0);
    run_period('0, '1);
    run_period('0, '0);
    check_eq("R11 field for dst 63", dut_front(63), front_m[63]);
    main_done = 1;
  endtask

  initial begin
    fork
      main_seq();
      begin
        repeat (190000) @(posedge clk);
      end
    join_any
    if (!main_done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual running expected finished");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule